// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block gives a host single-request access to a 16-bit register space inside a PHY that is reachable only through a narrow handshake. The PHY sees one control word from the block and returns one status word. The control word carries a 16-bit value together with four strobes. The status word returns a single acknowledge bit and 16 bits of read data. The host presents an address, write data and a direction for one cycle. The block then runs the whole handshake by itself and reports completion with a one-cycle pulse.

Each access is a chain of four-phase handshakes. First the address is captured. A write then captures the data and issues the write strobe. A read instead issues the read strobe and takes the returned value. In every phase the block raises a strobe, waits for the acknowledge to go high, drops the strobe and waits for the acknowledge to go low. Each wait samples the acknowledge a bounded number of times, with a fixed gap between samples. If the expected level never appears, the access is abandoned with an error.

Top module: `phy_hs_master`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), ctrl_word is 0 and busy, done and err are all 0.
- R2: ctrl_word[15:0] carries the address or data value, bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write strobe and bit 19 the read strobe. At most one of bits 19:16 is ever set.
- R3: Every access starts with the address phase, in which ctrl_word takes the successive values addr, addr|bit16 (held until acknowledge is high), then addr (held until acknowledge is low).
- R4: After the address phase, a write drives data, data|bit17 (until ack high), data (until ack low), bit18 alone (until ack high), data (until ack low), and then 0.
- R5: After the address phase, a read drives bit19 alone until ack is high, then 0 until ack is low. rd_data returns the value of stat_word[15:0] from the cycle in which ack was seen high, and keeps it until the next read completes.
- R6: Each wait samples stat_word[16] once on entry and then every POLL_CYCLES clocks, for at most MAX_POLLS samples. An expected level that appears before the last sample lets the access proceed.
- R7: If the last sample of a wait misses, the access aborts. ctrl_word returns to 0 before done, and err is 1 in the done cycle. An abort costs about (MAX_POLLS-1)*POLL_CYCLES cycles.
- R8: done is high for exactly one cycle per accepted request, and err is only ever high together with done.
- R9: A request presented while busy is high is ignored. It causes no access, no change to the access in progress and no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, accepted when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout error, valid with done |
| rd_data | output | 16 | Data returned by the last read |
| ctrl_word | output | 20 | Control word to the PHY |
| stat_word | input | 17 | Status from the PHY: bit 16 ack, bits 15:0 read data |

## Verification
The assertions take for granted that the PHY changes its acknowledge only in answer to a change of the strobes, and that the host issues requests as single-cycle pulses. The stimulus keeps within these limits. A bench model of the PHY toggles the acknowledge a programmable number of cycles after the strobe level changes, or holds it stuck at a fixed level to force a timeout. Requests are issued by one task as one-cycle pulses, except for a deliberate extra pulse sent while busy.

// File: rtl/phy_hs_pkg.sv
// Shared types for the indirect PHY access sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package phy_hs_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADR_SET,
        S_ADR_CAP,
        S_ADR_REL,
        S_DAT_SET,
        S_DAT_CAP,
        S_DAT_REL,
        S_WR_STB,
        S_WR_REL,
        S_RD_STB,
        S_RD_REL,
        S_CLEAR,
        S_RESP
    } hs_state_t;
endpackage

// File: rtl/phy_hs_poll.sv
// Poll timer: while enabled, pulses 'sample' on the first cycle and then every
// POLL_CYCLES clocks, and flags the final permitted sample with 'last'.
// Assumes 'clr' is raised whenever the sequencer changes state.
module phy_hs_poll #(
    parameter int POLL_CYCLES = 200,
    parameter int MAX_POLLS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic sample,
    output logic last
);
    localparam int CYW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int PLW = $clog2(MAX_POLLS + 1);

    logic [CYW-1:0] cyc_q;
    logic [PLW-1:0] polls_q;

    assign sample = en && (cyc_q == '0);
    assign last   = (polls_q == PLW'(MAX_POLLS - 1));

    // Count cycles between samples and the samples already taken.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cyc_q   <= '0;
            polls_q <= '0;
        end else if (en) begin
            cyc_q <= (cyc_q == CYW'(POLL_CYCLES - 1)) ? '0 : cyc_q + 1'b1;
            if (sample) polls_q <= polls_q + 1'b1;
        end
    end

    // R6
    // poll_bound_chk: the sample count never passes the permitted number.
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q <= PLW'(MAX_POLLS - 1));
endmodule

// File: rtl/phy_hs_encode.sv
// Control word encoder: maps the sequencer step and the latched address and
// data onto the value field and the four strobe bits above it.
// Assumes the step input is a registered state.
module phy_hs_encode
    import phy_hs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hs_state_t         st,
    input  logic [DW-1:0]     addr,
    input  logic [DW-1:0]     data,
    output logic [DW+3:0]     word
);
    localparam int B_CAPA = DW;
    localparam int B_CAPD = DW + 1;
    localparam int B_WR   = DW + 2;
    localparam int B_RD   = DW + 3;

    // Decode the step into the word driven to the PHY.
    always_comb begin
        word = '0;
        unique case (st)
            S_ADR_SET, S_ADR_REL: word[DW-1:0] = addr;
            S_ADR_CAP: begin
                word[DW-1:0]  = addr;
                word[B_CAPA]  = 1'b1;
            end
            S_DAT_SET, S_DAT_REL, S_WR_REL: word[DW-1:0] = data;
            S_DAT_CAP: begin
                word[DW-1:0]  = data;
                word[B_CAPD]  = 1'b1;
            end
            S_WR_STB:  word[B_WR] = 1'b1;
            S_RD_STB:  word[B_RD] = 1'b1;
            default:   word = '0;
        endcase
    end

    // R2
    // one_strobe_chk: never more than one strobe at a time.
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word[B_RD:B_CAPA]));
endmodule

// File: rtl/phy_hs_seq.sv
// Access sequencer: walks the address phase, then the data and write phases
// or the read phase, waiting on the acknowledge level at each handshake step.
// Assumes the PHY moves its ack only in answer to strobe changes.
module phy_hs_seq
    import phy_hs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW:0]   stat,
    input  logic          sample,
    input  logic          last,
    output hs_state_t     st,
    output logic          wait_en,
    output logic          step_chg,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] rdat_q,
    output logic          err_q
);
    hs_state_t st_n;
    logic      wr_q;
    logic      exp_ack;
    logic      hit;

    // Which steps wait, and for which ack level.
    always_comb begin
        wait_en = 1'b1;
        exp_ack = 1'b0;
        unique case (st)
            S_ADR_CAP, S_DAT_CAP, S_WR_STB, S_RD_STB: exp_ack = 1'b1;
            S_ADR_REL, S_DAT_REL, S_WR_REL, S_RD_REL: exp_ack = 1'b0;
            default: wait_en = 1'b0;
        endcase
    end

    assign hit = sample && (stat[DW] == exp_ack);

    // Next-step selection.
    always_comb begin
        st_n = st;
        if (wait_en && sample && !hit && last) begin
            st_n = S_CLEAR;
        end else begin
            unique case (st)
                S_IDLE:    if (req_valid) st_n = S_ADR_SET;
                S_ADR_SET: st_n = S_ADR_CAP;
                S_ADR_CAP: if (hit) st_n = S_ADR_REL;
                S_ADR_REL: if (hit) st_n = wr_q ? S_DAT_SET : S_RD_STB;
                S_DAT_SET: st_n = S_DAT_CAP;
                S_DAT_CAP: if (hit) st_n = S_DAT_REL;
                S_DAT_REL: if (hit) st_n = S_WR_STB;
                S_WR_STB:  if (hit) st_n = S_WR_REL;
                S_WR_REL:  if (hit) st_n = S_CLEAR;
                S_RD_STB:  if (hit) st_n = S_RD_REL;
                S_RD_REL:  if (hit) st_n = S_CLEAR;
                S_CLEAR:   st_n = S_RESP;
                default:   st_n = S_IDLE;
            endcase
        end
    end

    assign step_chg = (st_n != st);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // Latch the request when idle, the read value on ack, and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            wr_q   <= 1'b0;
            rdat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (st == S_IDLE && req_valid) begin
                addr_q <= req_addr;
                data_q <= req_wdata;
                wr_q   <= req_write;
                err_q  <= 1'b0;
            end
            if (st == S_RD_STB && hit) rdat_q <= stat[DW-1:0];
            if (wait_en && sample && !hit && last) err_q <= 1'b1;
        end
    end

    // R9
    // busy_hold_chk: the captured request stays put during an access.
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> $stable(addr_q) && $stable(data_q));
endmodule

// File: rtl/phy_hs_master.sv
// Top of the indirect PHY access sequencer: ties the sequencer, poll timer
// and control word encoder together and produces the host-side responses.
// Assumes req_valid is a single-cycle pulse; POLL_CYCLES clocks make 1 us.
module phy_hs_master
    import phy_hs_pkg::*;
#(
    parameter int DW          = 16,
    parameter int POLL_CYCLES = 200,
    parameter int MAX_POLLS   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [15:0]   req_addr,
    input  logic [15:0]   req_wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [15:0]   rd_data,
    output logic [19:0]   ctrl_word,
    input  logic [16:0]   stat_word
);
    hs_state_t     st;
    logic          wait_en, step_chg, sample, last, err_q;
    logic [DW-1:0] addr_q, data_q, rdat_q;

    phy_hs_seq #(.DW(DW)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .stat(stat_word), .sample(sample), .last(last),
        .st(st), .wait_en(wait_en), .step_chg(step_chg),
        .addr_q(addr_q), .data_q(data_q), .rdat_q(rdat_q), .err_q(err_q)
    );

    phy_hs_poll #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) i_poll (
        .clk(clk), .rst_n(rst_n), .clr(step_chg), .en(wait_en),
        .sample(sample), .last(last)
    );

    phy_hs_encode #(.DW(DW)) i_enc (
        .clk(clk), .rst_n(rst_n), .st(st),
        .addr(addr_q), .data(data_q), .word(ctrl_word)
    );

    assign busy    = (st != S_IDLE);
    assign done    = (st == S_RESP);
    assign err     = done && err_q;
    assign rd_data = rdat_q;

    // R8
    // done_pulse_chk: completion lasts a single cycle.
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    // err_with_done_chk: the error flag appears only with completion.
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R7
    // ctrl_idle_at_done_chk: the control word is already clear when done.
    ctrl_idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctrl_word == '0) && ($past(ctrl_word) == '0));
endmodule

// File: tb/test_phy_hs_master.sv
module test_phy_hs_master;
    localparam int PC  = 4;
    localparam int MXP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, err;
    logic [15:0] rd_data;
    logic [19:0] ctrl_word;
    logic [16:0] stat_word;

    always #2.5 clk = ~clk;

    phy_hs_master #(.POLL_CYCLES(PC), .MAX_POLLS(MXP)) i_phy_hs_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .ctrl_word(ctrl_word), .stat_word(stat_word)
    );

    // PHY model: ack follows the strobe level after dly cycles, or is stuck.
    int          dly = 0;
    logic        stuck = 1'b0, stuck_lvl = 1'b0;
    logic        want_q;
    int          since;
    logic [3:0]  pa;
    logic [15:0] dbuf;
    logic [15:0] mem [16];
    logic        ack;

    always @(posedge clk) begin
        if (!rst_n) begin
            want_q <= 1'b0; since <= 1000; pa <= '0; dbuf <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            if (ctrl_word[16] && !want_q) pa <= ctrl_word[3:0];
            if (ctrl_word[17] && !want_q) dbuf <= ctrl_word[15:0];
            if (ctrl_word[18] && !want_q) mem[pa] <= dbuf;
            if ((|ctrl_word[19:16]) != want_q) begin
                want_q <= |ctrl_word[19:16]; since <= 0;
            end else begin
                since <= since + 1;
            end
        end
    end
    assign ack = stuck ? stuck_lvl : ((since >= dly) ? want_q : !want_q);
    assign stat_word = {ack, ctrl_word[19] ? mem[pa] : 16'hBEEF};

    // Control word change log, sampled away from the active edge.
    logic [19:0] log_w [32];
    int          log_n = 0;
    logic [19:0] last_w = '0;
    always @(negedge clk) begin
        if (ctrl_word != last_w) begin
            if (log_n < 32) log_w[log_n] = ctrl_word;
            log_n = log_n + 1;
            last_w = ctrl_word;
        end
    end

    int errors = 0, checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Issue one request and wait for done; returns err, rd data and elapsed cycles.
    task automatic do_access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                             output logic e, output logic [15:0] r, output int el);
        int t0;
        @(negedge clk);
        log_n = 0; last_w = ctrl_word;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        t0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        el = 0;
        while (!done && el < 2000) begin @(negedge clk); el++; end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=no done expected=done");
        end
        e = err; r = rd_data; el = cyc - t0;
        chk("R7 ctrl zero at done", {12'h0, ctrl_word}, 32'h0);
        @(negedge clk);
        chk("R8 done one cycle", {31'h0, done}, 32'h0);
    endtask

    task automatic chk_seq(input string rq, input logic [19:0] ex [12], input int n);
        logic bad = (log_n != n);
        for (int i = 0; i < n && i < 32; i++) if (log_w[i] != ex[i]) bad = 1'b1;
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: actual=%0d words first=%h expected=%0d words first=%h",
                     rq, log_n, log_w[0], n, ex[0]);
        end
    endtask

    // {write, addr, data, ack delay}
    localparam logic [40:0] VEC [8] = '{
        {1'b1, 16'h0003, 16'hA5C3, 8'd0},
        {1'b1, 16'h000C, 16'h1234, 8'd3},
        {1'b1, 16'h0007, 16'hFFFF, 8'd20},
        {1'b0, 16'h0003, 16'h0000, 8'd1},
        {1'b0, 16'h000C, 16'h0000, 8'd20},
        {1'b1, 16'h0003, 16'h0F0F, 8'd5},
        {1'b0, 16'h0003, 16'h0000, 8'd2},
        {1'b0, 16'h0007, 16'h0000, 8'd0}
    };

    logic [15:0] shadow [16];

    initial begin
        logic        e;
        logic [15:0] r;
        int          el;
        logic [19:0] ex [12];
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", {12'h0, ctrl_word}, 0);
        chk("R1 busy", {31'h0, busy}, 0);
        chk("R1 done/err", {30'h0, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            logic        w = VEC[v][40];
            logic [15:0] a = VEC[v][39:24];
            logic [15:0] d = VEC[v][23:8];
            dly = int'(VEC[v][7:0]);
            do_access(w, a, d, e, r, el);
            chk("R6 no error", {31'h0, e}, 0);
            ex[0] = {4'h0, a}; ex[1] = {4'h1, a}; ex[2] = {4'h0, a};
            if (w) begin
                ex[3] = {4'h0, d}; ex[4] = {4'h2, d}; ex[5] = {4'h0, d};
                ex[6] = 20'h40000; ex[7] = {4'h0, d}; ex[8] = 20'h0;
                chk_seq("R4 R3 R2 write words", ex, 9);
                shadow[a[3:0]] = d;
            end else begin
                ex[3] = 20'h80000; ex[4] = 20'h0;
                chk_seq("R5 R3 R2 read words", ex, 5);
                chk("R5 read data", {16'h0, r}, {16'h0, shadow[a[3:0]]});
            end
        end
        // R5 read data holds after a write
        dly = 1;
        do_access(1'b1, 16'h0009, 16'h7777, e, r, el);
        chk("R5 rd_data held", {16'h0, rd_data}, {16'h0, shadow[7]});
        shadow[9] = 16'h7777;

        // R9 request during busy is ignored
        dly = 3;
        fork
            do_access(1'b1, 16'h0005, 16'h5555, e, r, el);
            begin
                repeat (6) @(negedge clk);
                req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0006; req_wdata = 16'h6666;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        shadow[5] = 16'h5555;
        repeat (4) @(negedge clk);
        chk("R9 no second access", {31'h0, busy}, 0);
        do_access(1'b0, 16'h0006, 16'h0, e, r, el);
        chk("R9 ignored write absent", {16'h0, r}, 32'h0);
        do_access(1'b0, 16'h0005, 16'h0, e, r, el);
        chk("R9 first write intact", {16'h0, r}, 32'h5555);

        // R7 timeout with ack stuck low: abort in address capture
        stuck = 1'b1; stuck_lvl = 1'b0;
        do_access(1'b1, 16'h000A, 16'h4321, e, r, el);
        chk("R7 err on stuck low", {31'h0, e}, 1);
        ex[0] = 20'h0000A; ex[1] = 20'h1000A; ex[2] = 20'h0;
        chk_seq("R7 abort words low", ex, 3);
        chk("R7 abort time", {31'h0, (el >= (MXP-1)*PC) && (el <= (MXP-1)*PC + 8)}, 1);
        // R7 timeout with ack stuck high: abort in address release
        stuck_lvl = 1'b1;
        do_access(1'b0, 16'h000B, 16'h0, e, r, el);
        chk("R7 err on stuck high", {31'h0, e}, 1);
        ex[0] = 20'h0000B; ex[1] = 20'h1000B; ex[2] = 20'h0000B; ex[3] = 20'h0;
        chk_seq("R7 abort words high", ex, 4);
        chk("R7 aborted read keeps rd_data", {16'h0, r}, 32'h5555);
        stuck = 1'b0;
        // R6 recovery and error clears
        dly = 2;
        do_access(1'b0, 16'h0009, 16'h0, e, r, el);
        chk("R6 recovered no err", {31'h0, e}, 0);
        chk("R6 recovered data", {16'h0, r}, 32'h7777);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #750000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule